// File: doc/BRIEF.md
# Per-pin GPIO peripheral multiplexer

This block is a register-controlled I/O port of `NPINS` pins. Each pin is either a general-purpose bit driven by software or is given to one of three peripheral functions. A 2-bit selector for each pin makes that choice. In GPIO mode a direction bit gates the pad driver, and the pad is driven from an output latch. In a peripheral mode the selected peripheral supplies both the pad value and the pad enable.

Software reaches the port through a small register bus. The bus has one write strobe and a combinational read port. The output latch can be written whole, or changed atomically through set, clear and toggle aliases. Reading the data address returns the live pin level, not the latch. The pin input level always fans out to the peripheral inputs, whatever the pins are muxed to. A per-pin pull-up disable register drives the pad pull-up enables.

Top module: `gpio_pinmux`

## Requirements
- R1: An active-low asynchronous reset sets every selector to 00, every direction bit to 0 and every latch bit to 0, and enables every pull-up. With reset applied, `pad_oe` is all zeros and `pad_pu_en` is all ones.
- R2: The select register is at address 0. The field of pin i is at bits [2i+1:2i]. Code 00 selects GPIO, and codes 01, 10 and 11 select peripheral 1, 2 and 3.
- R3: In GPIO mode, `pad_oe[i]` equals direction bit i (address 1; 1 means output) and `pad_out[i]` equals latch bit i.
- R4: In peripheral mode k, `pad_out[i]` equals `perf_out[(k-1)*NPINS+i]` and `pad_oe[i]` equals `perf_oe[(k-1)*NPINS+i]`. The direction bit has no effect on these pads.
- R5: A write to address 2 loads the latch from the low `NPINS` data bits. A read of address 2 returns `pad_in`.
- R6: A write to address 3 sets each latch bit that is written as 1. Bits written as 0 keep their value.
- R7: A write to address 4 clears each latch bit that is written as 1. Bits written as 0 keep their value.
- R8: A write to address 5 inverts each latch bit that is written as 1. Bits written as 0 keep their value.
- R9: The pull-up disable register is at address 6. `pad_pu_en[i]` is the inverse of bit i of that register.
- R10: `per_in` equals `pad_in` at all times, in every mux setting.
- R11: Reads of addresses 0, 1 and 6 return the stored values, with unused upper bits read as 0. Reads of addresses 3, 4, 5 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | NPINS | Pin input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu_en | output | NPINS | Pad pull-up enables |
| perf_out | input | 3*NPINS | Peripheral outputs; peripheral k at bits [(k-1)*NPINS +: NPINS] |
| perf_oe | input | 3*NPINS | Peripheral output enables, same packing |
| per_in | output | NPINS | Pin level sent to the peripherals |

## Verification
The bench aims at the following corner cases:
- The direction bit must have no effect on peripheral-owned pads. A design that let it through would drive a pad that the peripheral has released.
- Each peripheral supplies a different value and enable on the same pin. A selector decoded in the wrong order would therefore show the wrong peripheral at the pad.
- The highest pin's select field is used, which catches packing errors at the top bit pair.
- Data is read while the latch and `pad_in` differ. A design that returned the latch would fail this.
- The set, clear and toggle aliases are written with sparse masks. A design that wrote the whole latch would corrupt the bits left as 0.

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int NPINS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_pu_en,
  input  logic [3*NPINS-1:0]   perf_out,
  input  logic [3*NPINS-1:0]   perf_oe,
  output logic [NPINS-1:0]     per_in
);
  localparam logic [2:0] A_MODE = 3'd0, A_DIR = 3'd1, A_DATA = 3'd2, A_SET = 3'd3,
                         A_CLR  = 3'd4, A_TGL = 3'd5, A_PUD  = 3'd6;
  localparam int SW = 2 * NPINS;

  logic [SW-1:0]    mode_q;
  logic [NPINS-1:0] dir_q, dat_q, pud_q;
  wire  [NPINS-1:0] wmask = reg_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dat_q  <= '0;
      pud_q  <= '0;
    end else if (reg_wr) begin
      unique case (reg_addr)
        A_MODE:  mode_q <= reg_wdata[SW-1:0];
        A_DIR:   dir_q  <= wmask;
        A_PUD:   pud_q  <= wmask;
        A_CLR:   dat_q  <= dat_q & ~wmask;
        A_SET:   dat_q  <= dat_q | wmask;
        A_TGL:   dat_q  <= dat_q ^ wmask;
        A_DATA:  dat_q  <= wmask;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:  reg_rdata[SW-1:0]    = mode_q;
      A_DIR:   reg_rdata[NPINS-1:0] = dir_q;
      A_DATA:  reg_rdata[NPINS-1:0] = pad_in;
      A_PUD:   reg_rdata[NPINS-1:0] = pud_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pad_pu_en = ~pud_q;
  assign per_in    = pad_in;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    wire [1:0] sel = mode_q[2*i +: 2];
    always_comb begin
      case (sel)
        2'b01:   begin pad_out[i] = perf_out[i];           pad_oe[i] = perf_oe[i];           end
        2'b10:   begin pad_out[i] = perf_out[NPINS+i];     pad_oe[i] = perf_oe[NPINS+i];     end
        2'b11:   begin pad_out[i] = perf_out[2*NPINS+i];   pad_oe[i] = perf_oe[2*NPINS+i];   end
        default: begin pad_out[i] = dat_q[i];              pad_oe[i] = dir_q[i];             end
      endcase
    end
  end
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_addr,
  input logic             reg_wr,
  input logic [NPINS-1:0] wmask,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pu_en,
  input logic [NPINS-1:0] lat
);
  wire lat_wr = reg_wr && (reg_addr >= 3'd2) && (reg_addr <= 3'd5);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_pads_chk: assert (pad_oe == '0 && pad_pu_en == '1);
    end
  end

  // R6
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3) |=> ((lat & $past(wmask)) == $past(wmask)
                                      && ((lat ^ $past(lat)) & ~$past(wmask)) == '0));

  // R7
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4) |=> ((lat & $past(wmask)) == '0
                                      && ((lat ^ $past(lat)) & ~$past(wmask)) == '0));

  // R8
  tgl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5) |=> ((lat ^ $past(lat)) == $past(wmask)));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_wr |=> $stable(lat));
endmodule

bind gpio_pinmux gpio_pinmux_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .wmask(reg_wdata[NPINS-1:0]), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .lat(dat_q)
);

// File: tb/test_gpio_pinmux.sv
`timescale 1ns/1ps
module test_gpio_pinmux;
  localparam int N = 16;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [N-1:0] pad_in = 0, pad_out, pad_oe, pad_pu_en, per_in;
  logic [3*N-1:0] perf_out = 0, perf_oe = 0;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  gpio_pinmux #(.NPINS(N)) i_gpio_pinmux (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en),
    .perf_out(perf_out), .perf_oe(perf_oe), .per_in(per_in));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk("R1 oe", {16'h0, pad_oe}, 32'h0);
    chk("R1 pu", {16'h0, pad_pu_en}, 32'hffff);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, d); chk("R1 mode", d, 0);
    rd(3'd1, d); chk("R1 dir", d, 0);
  endtask

  task automatic t_gpio;
    logic [31:0] d;
    wr(3'd1, 32'hffffffff);
    wr(3'd2, 32'h0000a5a5);
    chk("R3 out", {16'h0, pad_out}, 32'ha5a5);
    chk("R3 oe", {16'h0, pad_oe}, 32'hffff);
    pad_in = 16'h1234;
    rd(3'd2, d); chk("R5 read pin", d, 32'h1234);
    wr(3'd1, 32'h0000000f);
    chk("R3 dir", {16'h0, pad_oe}, 32'h000f);
    wr(3'd1, 32'hffffffff);
  endtask

  task automatic t_atomic;
    wr(3'd2, 32'h000000f0);
    wr(3'd3, 32'h0000000f); chk("R6 set", {16'h0, pad_out}, 32'h00ff);
    wr(3'd4, 32'h00000011); chk("R7 clr", {16'h0, pad_out}, 32'h00ee);
    wr(3'd5, 32'h0000ff0f); chk("R8 tgl", {16'h0, pad_out}, 32'hffe1);
  endtask

  task automatic t_periph;
    perf_out = {16'h8004, 16'hfffd, 16'h0001};
    perf_oe  = {16'h8000, 16'h0002, 16'h0001};
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hc0000039);
    chk("R4 out", {29'h0, pad_out[2:0]}, 32'h5);
    chk("R4 oe", {29'h0, pad_oe[2:0]}, 32'h3);
    chk("R2 top pin", {30'h0, pad_out[15], pad_oe[15]}, 32'h3);
    wr(3'd1, 32'hffffffff);
    chk("R4 dir ignored", {29'h0, pad_oe[2:0]}, 32'h3);
    chk("R3 gpio pin3", {31'h0, pad_oe[3]}, 32'h1);
  endtask

  task automatic t_fanout;
    logic [31:0] d;
    pad_in = 16'h0005; #1;
    chk("R10 fanout", {16'h0, per_in}, 32'h0005);
    rd(3'd2, d); chk("R5 read muxed", d, 32'h0005);
    pad_in = 16'hbeef; #1;
    chk("R10 fanout2", {16'h0, per_in}, 32'hbeef);
  endtask

  task automatic t_pull;
    logic [31:0] d;
    wr(3'd6, 32'hffff00ff);
    chk("R9 pu", {16'h0, pad_pu_en}, 32'hff00);
    rd(3'd6, d); chk("R9 read", d, 32'hff00ff & 32'hffff);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    rd(3'd0, d); chk("R11 mode", d, 32'hc0000039);
    rd(3'd1, d); chk("R11 dir", d, 32'h0000ffff);
    rd(3'd3, d); chk("R11 set", d, 0);
    rd(3'd4, d); chk("R11 clr", d, 0);
    rd(3'd5, d); chk("R11 tgl", d, 0);
    rd(3'd7, d); chk("R11 unused", d, 0);
  endtask

  initial begin
    fork
      begin
        t_reset; t_gpio; t_atomic; t_periph; t_fanout; t_pull; t_readback;
      end
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule